// File: doc/BRIEF.md
# Flash command mode decoder

This block interprets bus write cycles for a parallel NOR-style memory model. It moves between four mode groups: plain array reads, identifier reads, query-table reads, and an erase phase. It selects the word returned on every read. The array storage and the erase engine sit outside the block. The decoder passes the array word through when array reads are active. It serves identifier words and a 64-word constant query table from inside. While an erase runs or after one fails, it returns the status word supplied by the erase engine.

Query mode remembers which mode it was entered from, so a reset command unwinds one level at a time. A six-write command starts a chip erase: the decoder emits a one-cycle start pulse, then ignores every write until the engine drops its busy line. If the engine reports an error at that point, status reads persist until a reset command arrives.

All command values are compared against the whole data word. Addresses are word addresses on a 12-bit bus. Reads are combinational from the current mode and `bus_addr`.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset the block is in array-read mode: `rd_data` equals `array_rdata` and `erase_start` is low.
- R2: A single write of 0x0098 to address 0x055, made in array-read or identifier mode, enters query mode. Reads in query mode return the table word for index `bus_addr[5:0]`. Indices 16, 17 and 18 return 0x0051, 0x0052 and 0x0059. Every other index i returns i XOR 0x00A5.
- R3: A write of 0x0098 to 0x055 is ignored in query, erase and error modes. In query mode it leaves the remembered return mode unchanged.
- R4: A reset command is a write of 0x00F0 to any address. If query mode was entered from array-read mode, a reset command returns the block to array-read mode.
- R5: If query mode was entered from identifier mode, the first reset command returns to identifier mode and a second reaches array-read mode.
- R6: The writes 0x00AA@0x555, 0x0055@0x2AA, 0x0090@0x555 enter identifier mode. In that mode, address 0 reads 0x0020, address 1 reads 0x22ED and other addresses read 0. A reset command leaves identifier mode for array-read mode.
- R7: Any write that breaks an unlock sequence returns the sequence to its start. The partial sequence has no effect, and reads stay in the current mode.
- R8: The writes 0x00AA@0x555, 0x0055@0x2AA, 0x0080@0x555, 0x00AA@0x555, 0x0055@0x2AA, 0x0010@0x555, issued in array-read or identifier mode, raise `erase_start` for exactly one cycle, in the cycle after the sixth write.
- R9: From the start pulse until `eng_busy` falls, every write is ignored, including reset, suspend (0x00B0) and a repeated erase sequence. No further start pulse is produced.
- R10: During the erase, reads return `eng_status`.
- R11: When busy falls, the block returns to array-read mode if `eng_err` is low. If `eng_err` is high, reads keep returning `eng_status` until a reset command, which then restores array-read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | One-cycle strobe marking a bus write |
| bus_addr | input | AW | Word address for reads and writes |
| bus_wdata | input | DW | Write data / command word |
| array_rdata | input | DW | Word read from the external array at `bus_addr` |
| eng_busy | input | 1 | Erase engine running, high from the cycle after the start pulse |
| eng_err | input | 1 | Erase engine failure flag, valid when busy falls |
| eng_status | input | DW | Status word from the erase engine |
| rd_data | output | DW | Read data selected by the current mode |
| erase_start | output | 1 | One-cycle request to begin a chip erase |

## Verification
A wrong mode register shows up at the very next read: `rd_data` draws from the wrong source. The bench reads after every mode-changing write, so such a fault is visible within two cycles. A corrupted return-mode flag stays hidden until a reset in query mode, so the bench unwinds from both origins. A leaky erase lock shows as status reads turning into array data, or as a second start pulse, before the engine finishes.

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter logic [15:0] MFR_ID = 16'h0020,
  parameter logic [15:0] DEV_ID = 16'h22ED
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] array_rdata,
  input  logic          eng_busy,
  input  logic          eng_err,
  input  logic [DW-1:0] eng_status,
  output logic [DW-1:0] rd_data,
  output logic          erase_start
);

  typedef enum logic [2:0] {M_READ, M_ID, M_QUERY, M_ERASE, M_ERR} mode_t;
  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_E3, S_E4, S_E5} seq_t;

  mode_t mode, mode_n;
  seq_t  seq, seq_n;
  logic  q_from_id, q_from_id_n, start_n;

  wire at_555   = bus_addr == AW'(12'h555);
  wire at_2aa   = bus_addr == AW'(12'h2AA);
  wire is_reset = bus_we && bus_wdata == DW'(8'hF0);
  wire is_query = bus_we && bus_wdata == DW'(8'h98) && bus_addr == AW'(8'h55);

  function automatic logic match(input logic a, input logic [DW-1:0] d, input logic [7:0] c);
    return a && d == DW'(c);
  endfunction

  function automatic logic [DW-1:0] qrom(input logic [5:0] i);
    case (i)
      6'h10:   return DW'(8'h51);
      6'h11:   return DW'(8'h52);
      6'h12:   return DW'(8'h59);
      default: return DW'({2'b00, i} ^ 8'hA5);
    endcase
  endfunction

  always_comb begin
    mode_n = mode;
    seq_n = seq;
    q_from_id_n = q_from_id;
    start_n = 1'b0;
    case (mode)
      M_READ, M_ID: if (bus_we) begin
        seq_n = S_IDLE;
        if (is_reset) mode_n = M_READ;
        else if (is_query) begin
          mode_n = M_QUERY;
          q_from_id_n = (mode == M_ID);
        end else case (seq)
          S_IDLE: if (match(at_555, bus_wdata, 8'hAA)) seq_n = S_U1;
          S_U1:   if (match(at_2aa, bus_wdata, 8'h55)) seq_n = S_U2;
          S_U2:   if (match(at_555, bus_wdata, 8'h90)) mode_n = M_ID;
                  else if (match(at_555, bus_wdata, 8'h80)) seq_n = S_E3;
          S_E3:   if (match(at_555, bus_wdata, 8'hAA)) seq_n = S_E4;
          S_E4:   if (match(at_2aa, bus_wdata, 8'h55)) seq_n = S_E5;
          S_E5:   if (match(at_555, bus_wdata, 8'h10)) begin
                    mode_n = M_ERASE;
                    start_n = 1'b1;
                  end
          default: seq_n = S_IDLE;
        endcase
      end
      M_QUERY: if (is_reset) mode_n = q_from_id ? M_ID : M_READ;
      M_ERASE: if (!erase_start && !eng_busy) mode_n = eng_err ? M_ERR : M_READ;
      M_ERR:   if (is_reset) mode_n = M_READ;
      default: mode_n = M_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= M_READ;
      seq <= S_IDLE;
      q_from_id <= 1'b0;
      erase_start <= 1'b0;
    end else begin
      mode <= mode_n;
      seq <= seq_n;
      q_from_id <= q_from_id_n;
      erase_start <= start_n;
    end
  end

  always_comb begin
    case (mode)
      M_ID:           rd_data = bus_addr[5:0] == 6'd0 ? DW'(MFR_ID) :
                                bus_addr[5:0] == 6'd1 ? DW'(DEV_ID) : '0;
      M_QUERY:        rd_data = qrom(bus_addr[5:0]);
      M_ERASE, M_ERR: rd_data = eng_status;
      default:        rd_data = array_rdata;
    endcase
  end

  assert_start_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);

  assert_start_enters_erase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_start) |-> (mode == M_ERASE && $past(mode) != M_ERASE));

  assert_erase_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERASE && eng_busy) |=> (mode == M_ERASE && !erase_start));

  assert_err_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ERR && !is_reset) |=> mode == M_ERR);

  assert_query_unwind_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_QUERY && q_from_id && is_reset) |=> mode == M_ID);

  assert_query_ignores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_QUERY && !is_reset) |=> (mode == M_QUERY && $stable(q_from_id)));

endmodule

// File: tb/flash_cmd_decoder_tb_top.sv
module flash_cmd_decoder_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] array_rdata, eng_status, rd_data;
  logic eng_busy, eng_err, erase_start;
  logic err_sel = 1'b0;
  logic [7:0] eng_cnt;
  int n_chk = 0, n_fail = 0, start_count = 0;
  bit mon_req = 1'b0;

  typedef struct { logic [15:0] exp; string tag; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  assign array_rdata = {4'hA, bus_addr};
  assign eng_busy = eng_cnt != 0;
  assign eng_err = err_sel;
  assign eng_status = eng_busy ? 16'h0088 : 16'h0028;

  always_ff @(posedge clk) begin
    if (!rst_n) eng_cnt <= '0;
    else if (erase_start) eng_cnt <= 8'd60;
    else if (eng_cnt != 0) eng_cnt <= eng_cnt - 8'd1;
  end

  always @(posedge clk) if (rst_n && erase_start) start_count++;

  flash_cmd_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .array_rdata(array_rdata), .eng_busy(eng_busy),
    .eng_err(eng_err), .eng_status(eng_status), .rd_data(rd_data),
    .erase_start(erase_start)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_req) begin
      item_t it;
      it = sb.pop_front();
      check(rd_data, it.exp, it.tag);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [15:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a; mon_req = 1'b1;
    sb.push_back('{exp, tag});
    @(negedge clk); #1;
    mon_req = 1'b0;
  endtask

  function automatic logic [15:0] arr(input logic [11:0] a);
    return {4'hA, a};
  endfunction

  function automatic logic [15:0] qexp(input int i);
    if (i == 16) return 16'h0051;
    if (i == 17) return 16'h0052;
    if (i == 18) return 16'h0059;
    return 16'(i[7:0] ^ 8'hA5);
  endfunction

  task automatic unlock3(input logic [15:0] c);
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h555, c);
  endtask

  task automatic erase_cmd();
    unlock3(16'h0080);
    unlock3(16'h0010);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    rd(12'h123, arr(12'h123), "R1 array read after reset");
    check(16'(start_count), 16'd0, "R1 no start after reset");
    // R2 query entry from array mode, R4 single reset back
    wr(12'h055, 16'h0098);
    rd(12'h010, qexp(16), "R2 query idx16");
    rd(12'h012, qexp(18), "R2 query idx18");
    rd(12'h03F, qexp(63), "R2 query idx63");
    rd(12'h047, qexp(7), "R2 query idx7");
    wr(12'h100, 16'h00F0);
    rd(12'h047, arr(12'h047), "R4 reset back to array");
    // R6 identifier mode
    unlock3(16'h0090);
    rd(12'h000, 16'h0020, "R6 id word0");
    rd(12'h001, 16'h22ED, "R6 id word1");
    rd(12'h005, 16'h0000, "R6 id other");
    // R2 query from id, R3 repeated entry ignored, R5 two-step unwind
    wr(12'h055, 16'h0098);
    rd(12'h011, qexp(17), "R2 query from id");
    wr(12'h055, 16'h0098);
    rd(12'h012, qexp(18), "R3 second entry ignored");
    wr(12'h000, 16'h00F0);
    rd(12'h001, 16'h22ED, "R5 first reset to id");
    wr(12'h000, 16'h00F0);
    rd(12'h001, arr(12'h001), "R5 second reset to array");
    // R6 reset out of id directly
    unlock3(16'h0090);
    wr(12'h3C0, 16'h00F0);
    rd(12'h000, arr(12'h000), "R6 reset leaves id");
    // R7 broken unlock sequences
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0012); wr(12'h555, 16'h0090);
    rd(12'h000, arr(12'h000), "R7 wrong data restarts");
    wr(12'h555, 16'h00AA); wr(12'h2AA, 16'h0055); wr(12'h554, 16'h0090);
    rd(12'h001, arr(12'h001), "R7 wrong address restarts");
    unlock3(16'h0090);
    rd(12'h000, 16'h0020, "R7 full sequence after restart");
    wr(12'h000, 16'h00F0);
    // R8 erase from array mode, R9 lock, R10 status
    err_sel = 1'b0;
    erase_cmd();
    check(16'(erase_start), 16'd1, "R8 start after sixth write");
    @(posedge clk); #1;
    check(16'(erase_start), 16'd0, "R8 start one cycle");
    rd(12'h200, 16'h0088, "R10 status during erase");
    wr(12'h055, 16'h0098);
    wr(12'h000, 16'h00F0);
    wr(12'h000, 16'h00B0);
    rd(12'h055, 16'h0088, "R9 commands ignored in erase");
    erase_cmd();
    rd(12'h010, 16'h0088, "R9 still erasing");
    check(16'(start_count), 16'd1, "R9 no second start");
    repeat (70) @(posedge clk);
    rd(12'h321, arr(12'h321), "R11 clean finish to array");
    // R11 erase from id ending in error
    err_sel = 1'b1;
    unlock3(16'h0090);
    erase_cmd();
    repeat (70) @(posedge clk);
    rd(12'h321, 16'h0028, "R11 error status held");
    wr(12'h055, 16'h0098);
    rd(12'h010, 16'h0028, "R3 query ignored in error");
    wr(12'h000, 16'h00F0);
    rd(12'h010, arr(12'h010), "R11 reset clears error");
    check(16'(start_count), 16'd2, "R8 start count total");
    repeat (2) @(posedge clk);
    summary();
    $finish;
  end
endmodule